// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is a single direct-memory-access channel. It copies bytes or 16-bit words from a source address to a destination address over a simple synchronous memory bus, with no processor involvement. Software sets up the configuration inputs, then pulses `en_set` to arm the channel. A selected trigger line then starts the transfers.

Each transfer is a read cycle followed by a write cycle and one wait cycle. One synchronization cycle comes before each single transfer, and before each whole block or burst-block. The source and destination widths are chosen independently. When a byte is written into a word location, the upper half is zero-filled. When a word is written into a byte location, only its low half is kept.

`cpu_hold` is high while the channel owns the bus. In burst-block mode the channel hands the bus back for two cycles after every four transfers. When the transfer count reaches zero the channel sets its flag. In the repeated modes it then reloads its counters. In the other modes it disarms itself.

Top module: `dma_channel`

## Requirements
- R1: Each address side steps after every transfer according to its own 2-bit mode: 0 or 3 leave the address unchanged, 1 increments it, and 2 decrements it. The step is 1 for a byte access and 2 for a word access.
- R2: A word-to-byte move (`cfg_src_word`=1, `cfg_dst_word`=0) writes only the low byte of the source word to the destination byte.
- R3: A byte-to-word move (`cfg_src_word`=0, `cfg_dst_word`=1) writes a word whose upper byte is zero and whose lower byte is the source byte.
- R4: In single mode (`cfg_mode[1:0]`=0), each accepted trigger moves exactly one item.
- R5: In block mode (`cfg_mode[1:0]`=1), one trigger moves the whole block. `cpu_hold` stays high without a break for 1 + 3·N cycles for N transfers, and is high whenever the bus is in use.
- R6: In burst-block mode (`cfg_mode[1:0]`=2 or 3), `cpu_hold` drops for exactly 2 cycles after every 4 transfers that do not end the block.
- R7: With `cfg_level`=0 the trigger is edge-sensitive: a rising edge of the selected line starts one service, however long the line stays high. With `cfg_level`=1 the channel keeps starting services while the line is high.
- R8: A read request is always followed in the next cycle by the matching write, and then by one cycle with no request. Writes inside a block are therefore exactly 3 cycles apart.
- R9: When the count reaches zero, `dma_flag` is set in every mode and stays set until `flag_clr`. `irq` is high only when `dma_flag`, `cfg_ie` and `gie` are all high.
- R10: In the repeated modes (`cfg_mode[2]`=1) the addresses and count reload from the configuration at the end of a block, and `ch_en` stays high. Otherwise `ch_en` clears at the end of the block.
- R11: A loaded count of zero, or a cleared `ch_en`, makes the channel ignore triggers, with no bus request and no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_size | input | SW | Transfers per block |
| cfg_src_step | input | 2 | Source step mode |
| cfg_dst_step | input | 2 | Destination step mode |
| cfg_src_word | input | 1 | Source is word (1) or byte (0) |
| cfg_dst_word | input | 1 | Destination is word (1) or byte (0) |
| cfg_mode | input | 3 | [1:0] single/block/burst, [2] repeat |
| cfg_tsel | input | log2(NTRIG) | Trigger line select |
| cfg_level | input | 1 | Level-sensitive trigger when 1 |
| cfg_ie | input | 1 | Channel interrupt enable |
| gie | input | 1 | Global interrupt enable |
| en_set | input | 1 | Arm channel and load counters |
| en_clr | input | 1 | Disarm channel |
| flag_clr | input | 1 | Clear completion flag |
| trig | input | NTRIG | Trigger lines |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Write when 1, read when 0 |
| mem_byte | output | 1 | Byte access when 1 |
| mem_addr | output | AW | Bus address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read |
| cpu_hold | output | 1 | Processor held off the bus |
| ch_en | output | 1 | Channel armed |
| dma_flag | output | 1 | Block-complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the configuration inputs stay stable while a service is in progress. They also assume that `en_set` and `en_clr` are pulsed only while the channel is idle, and that memory returns read data in the cycle after a read request. The bench changes the configuration and arms or disarms the channel only after the previous block has ended. It places random source and destination windows in disjoint halves of the memory model. Read data for byte reads carries a nonzero upper half, so that the zero-fill rule is actually exercised.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam int DW          = 16;
    localparam int BURST_BEATS = 4;
    localparam int RELEASE_CYC = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SYNC, ST_RD, ST_WR, ST_WAIT, ST_BREL
    } dma_state_e;

    typedef enum logic [1:0] {
        XF_SINGLE = 2'd0,
        XF_BLOCK  = 2'd1,
        XF_BURST  = 2'd2,
        XF_BURSTX = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic       rpt;
        xfer_kind_e kind;
    } mode_t;

    // Data leaving the channel: byte sources are zero-extended.
    function automatic logic [DW-1:0] pack_beat(input logic [DW-1:0] rd,
                                                input logic src_word);
        return src_word ? rd : {8'h00, rd[7:0]};
    endfunction

endpackage

// File: rtl/dma_trig_sel.sv
module dma_trig_sel #(
    parameter int NTRIG = 4,
    parameter int TSW   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTRIG-1:0] trig,
    input  logic [TSW-1:0]   tsel,
    input  logic             level,
    input  logic             en,
    input  logic             take,
    output logic             fire
);
    logic sel, sel_q, pend;

    assign sel = trig[tsel];

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            sel_q <= sel;
            if (!en)                pend <= 1'b0;
            else if (sel && !sel_q) pend <= 1'b1;
            else if (take)          pend <= 1'b0;
        end
    end

    assign fire = level ? sel : pend;

    AST_EDGE_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        (!level && take && !(sel && !sel_q)) |=> !pend) else $error("edge kept"); // R7

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] base,
    input  logic [1:0]    step,
    input  logic          word,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] delta;

    assign delta = word ? AW'(2) : AW'(1);

    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= base;
        else if (adv) begin
            case (step)
                2'd1:    addr <= addr + delta;
                2'd2:    addr <= addr - delta;
                default: addr <= addr;
            endcase
        end
    end

    AST_ADDR_FIXED: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && step[0] == step[1]) |=> $stable(addr)) else $error("fixed moved"); // R1

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl
    import dma_pkg::*;
#(
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  mode_t         mode,
    input  logic [SW-1:0] cfg_size,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic          flag_clr,
    output dma_state_e    state,
    output logic          take,
    output logic          load,
    output logic          adv,
    output logic          en,
    output logic          flag
);
    localparam int BCW = $clog2(BURST_BEATS + 1);
    localparam int RCW = $clog2(RELEASE_CYC + 1);

    logic [SW-1:0]  cnt;
    logic [BCW-1:0] bc;
    logic [RCW-1:0] rc;
    logic           last, burst;
    dma_state_e     nxt;

    assign last  = (state == ST_WAIT) && (cnt == '0);
    assign burst = mode.kind[1];
    assign take  = (state == ST_IDLE) && en && (cnt != '0) && fire;
    assign load  = en_set || (last && mode.rpt);
    assign adv   = (state == ST_WR);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (take) nxt = ST_SYNC;
            ST_SYNC: nxt = ST_RD;
            ST_RD:   nxt = ST_WR;
            ST_WR:   nxt = ST_WAIT;
            ST_WAIT: begin
                if (last || mode.kind == XF_SINGLE) nxt = ST_IDLE;
                else if (burst && bc == BCW'(BURST_BEATS)) nxt = ST_BREL;
                else nxt = ST_RD;
            end
            ST_BREL: if (rc == RCW'(RELEASE_CYC - 1)) nxt = ST_RD;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bc    <= '0;
            rc    <= '0;
            en    <= 1'b0;
            flag  <= 1'b0;
        end else begin
            state <= nxt;
            if (load)     cnt <= cfg_size;
            else if (adv) cnt <= cnt - 1'b1;
            if (state == ST_SYNC || state == ST_BREL) bc <= '0;
            else if (adv) bc <= bc + 1'b1;
            rc <= (state == ST_BREL) ? rc + 1'b1 : '0;
            if (en_set)                 en <= 1'b1;
            else if (en_clr)            en <= 1'b0;
            else if (last && !mode.rpt) en <= 1'b0;
            if (last)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !en) |=> state == ST_IDLE) else $error("start while off"); // R11
    AST_BREL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BREL && $past(state) != ST_BREL) |=> state == ST_BREL) else $error("short release"); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag) else $error("flag lost"); // R9

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW    = 16,
    parameter int SW    = 16,
    parameter int NTRIG = 4,
    localparam int TSW  = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic [SW-1:0]    cfg_size,
    input  logic [1:0]       cfg_src_step,
    input  logic [1:0]       cfg_dst_step,
    input  logic             cfg_src_word,
    input  logic             cfg_dst_word,
    input  logic [2:0]       cfg_mode,
    input  logic [TSW-1:0]   cfg_tsel,
    input  logic             cfg_level,
    input  logic             cfg_ie,
    input  logic             gie,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic             flag_clr,
    input  logic [NTRIG-1:0] trig,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_byte,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic             cpu_hold,
    output logic             ch_en,
    output logic             dma_flag,
    output logic             irq
);
    dma_state_e    state;
    logic          fire, take, load, adv;
    logic [AW-1:0] src_addr, dst_addr;

    dma_trig_sel #(.NTRIG(NTRIG), .TSW(TSW)) u_trig (
        .clk(clk), .rst(rst), .trig(trig), .tsel(cfg_tsel), .level(cfg_level),
        .en(ch_en), .take(take), .fire(fire)
    );

    dma_ctrl #(.SW(SW)) u_ctrl (
        .clk(clk), .rst(rst), .fire(fire), .mode(mode_t'(cfg_mode)),
        .cfg_size(cfg_size), .en_set(en_set), .en_clr(en_clr), .flag_clr(flag_clr),
        .state(state), .take(take), .load(load), .adv(adv), .en(ch_en), .flag(dma_flag)
    );

    dma_addr_ctr #(.AW(AW)) u_src (
        .clk(clk), .rst(rst), .load(load), .adv(adv), .base(cfg_src),
        .step(cfg_src_step), .word(cfg_src_word), .addr(src_addr)
    );

    dma_addr_ctr #(.AW(AW)) u_dst (
        .clk(clk), .rst(rst), .load(load), .adv(adv), .base(cfg_dst),
        .step(cfg_dst_step), .word(cfg_dst_word), .addr(dst_addr)
    );

    assign mem_req   = (state == ST_RD) || (state == ST_WR);
    assign mem_we    = (state == ST_WR);
    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_byte  = mem_we ? !cfg_dst_word : !cfg_src_word;
    assign mem_wdata = pack_beat(mem_rdata, cfg_src_word);
    assign cpu_hold  = (state != ST_IDLE) && (state != ST_BREL);
    assign irq       = dma_flag && cfg_ie && gie;

    AST_HOLD_COVERS_BUS: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> cpu_hold) else $error("bus used without hold"); // R5
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (mem_req && mem_we)) else $error("no write after read"); // R8
    AST_WAIT_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> !mem_req) else $error("no wait cycle"); // R8
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && !mem_byte && !cfg_src_word) |-> mem_wdata[15:8] == 8'h00)
        else $error("upper byte not cleared"); // R3

endmodule

// File: tb/dma_channel_tb.sv
`timescale 1ns/1ps
module dma_channel_tb;
    localparam int AW = 16, SW = 16, NTRIG = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic [AW-1:0] cfg_src = '0, cfg_dst = '0;
    logic [SW-1:0] cfg_size = '0;
    logic [1:0] cfg_src_step = 2'd1, cfg_dst_step = 2'd1;
    logic cfg_src_word = 1'b1, cfg_dst_word = 1'b1;
    logic [2:0] cfg_mode = 3'd1;
    logic [1:0] cfg_tsel = 2'd0;
    logic cfg_level = 1'b0, cfg_ie = 1'b1, gie = 1'b1;
    logic en_set = 1'b0, en_clr = 1'b0, flag_clr = 1'b0;
    logic [NTRIG-1:0] trig = '0;
    logic mem_req, mem_we, mem_byte, cpu_hold, ch_en, dma_flag, irq;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    dma_channel #(.AW(AW), .SW(SW), .NTRIG(NTRIG)) u_dut (
        .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_size(cfg_size),
        .cfg_src_step(cfg_src_step), .cfg_dst_step(cfg_dst_step),
        .cfg_src_word(cfg_src_word), .cfg_dst_word(cfg_dst_word), .cfg_mode(cfg_mode),
        .cfg_tsel(cfg_tsel), .cfg_level(cfg_level), .cfg_ie(cfg_ie), .gie(gie),
        .en_set(en_set), .en_clr(en_clr), .flag_clr(flag_clr), .trig(trig),
        .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_hold(cpu_hold),
        .ch_en(ch_en), .dma_flag(dma_flag), .irq(irq)
    );

    // memory model and monitors
    logic [7:0] mem_m [0:511];
    logic [7:0] exp_m [0:511];
    int cyc = 0, nwr = 0, nrise = 0, nfall = 0, last_fall = 0;
    int wr_t [0:63];
    int rise_t [0:63];
    logic hold_q = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        hold_q <= cpu_hold;
        if (cpu_hold && !hold_q) begin rise_t[nrise % 64] <= cyc; nrise <= nrise + 1; end
        if (!cpu_hold && hold_q) begin last_fall <= cyc; nfall <= nfall + 1; end
        if (mem_req && !mem_we) begin
            if (mem_byte) mem_rdata <= {8'hA5, mem_m[mem_addr[8:0]]};
            else mem_rdata <= {mem_m[{mem_addr[8:1], 1'b1}], mem_m[{mem_addr[8:1], 1'b0}]};
        end
        if (mem_req && mem_we) begin
            wr_t[nwr % 64] <= cyc;
            nwr <= nwr + 1;
            if (mem_byte) mem_m[mem_addr[8:0]] <= mem_wdata[7:0];
            else begin
                mem_m[{mem_addr[8:1], 1'b0}] <= mem_wdata[7:0];
                mem_m[{mem_addr[8:1], 1'b1}] <= mem_wdata[15:8];
            end
        end
    end

    int checks = 0, fails = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int stepv(input int st, input bit w);
        if (st == 1) return w ? 2 : 1;
        if (st == 2) return w ? -2 : -1;
        return 0;
    endfunction

    task automatic ref_move(input int s, input int d, input int n, input int ss,
                            input int ds, input bit sw, input bit dw);
        for (int i = 0; i < n; i++) begin
            logic [15:0] v;
            if (sw) v = {exp_m[(s & 'h1FE) | 1], exp_m[s & 'h1FE]};
            else    v = {8'h00, exp_m[s]};
            if (dw) begin
                exp_m[d & 'h1FE] = v[7:0];
                exp_m[(d & 'h1FE) | 1] = v[15:8];
            end else exp_m[d] = v[7:0];
            s = (s + stepv(ss, sw)) & 'h1FF;
            d = (d + stepv(ds, dw)) & 'h1FF;
        end
    endtask

    task automatic fill(input int lo, input int hi);
        for (int i = lo; i < hi; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            mem_m[i] = b;
            exp_m[i] = b;
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        for (int i = 0; i < 512; i++) if (mem_m[i] !== exp_m[i]) bad++;
        chk(req, "memory mismatches", bad, 0);
    endtask

    task automatic setup(input int s, input int d, input int n, input int ss, input int ds,
                         input bit sw, input bit dw, input int md, input bit lvl, input int ts);
        @(negedge clk);
        cfg_src = AW'(s); cfg_dst = AW'(d); cfg_size = SW'(n);
        cfg_src_step = 2'(ss); cfg_dst_step = 2'(ds);
        cfg_src_word = sw; cfg_dst_word = dw; cfg_mode = 3'(md);
        cfg_level = lvl; cfg_tsel = 2'(ts);
    endtask

    task automatic pulse_en;
        @(negedge clk) en_set = 1'b1;
        @(negedge clk) en_set = 1'b0;
    endtask

    task automatic pulse_trig(input int ts);
        @(negedge clk) trig[ts] = 1'b1;
        @(negedge clk) trig[ts] = 1'b0;
    endtask

    task automatic clr_flag;
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic wait_flag(input string req);
        int n = 0;
        while (!dma_flag && n < 3000) begin @(negedge clk); n++; end
        chk(req, "flag before timeout", int'(dma_flag), 1);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        fill(0, 512);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R5", "hold after reset", int'(cpu_hold), 0);
        chk("R8", "req after reset", int'(mem_req), 0);
        chk("R10", "enable after reset", int'(ch_en), 0);
        chk("R9", "flag after reset", int'(dma_flag), 0);

        // Block, word to word, both incrementing
        begin
            int w0, f0, r0;
            setup(16, 300, 6, 1, 1, 1, 1, 1, 0, 2);
            ref_move(16, 300, 6, 1, 1, 1, 1);
            pulse_en();
            w0 = nwr; f0 = nfall; r0 = nrise;
            pulse_trig(2);
            wait_flag("R5");
            chk("R5", "block writes", nwr - w0, 6);
            chk("R5", "hold segments", nrise - r0, 1);
            chk("R5", "hold length", last_fall - rise_t[r0 % 64], 19);
            chk("R8", "write spacing", wr_t[(w0 + 5) % 64] - wr_t[w0 % 64], 15);
            chk("R10", "enable cleared", int'(ch_en), 0);
            chk("R9", "irq enabled", int'(irq), 1);
            cmp_mem("R1");
            @(negedge clk) gie = 1'b0;
            #1 chk("R9", "irq gated by gie", int'(irq), 0);
            @(negedge clk) gie = 1'b1; cfg_ie = 1'b0;
            #1 chk("R9", "irq gated by ie", int'(irq), 0);
            cfg_ie = 1'b1;
            clr_flag();
            chk("R9", "flag cleared", int'(dma_flag), 0);
            if (f0 < 0) $display("unused");
        end

        // Burst-block, byte to word, 10 items
        begin
            int w0, r0;
            setup(40, 320, 10, 1, 1, 0, 1, 2, 0, 0);
            ref_move(40, 320, 10, 1, 1, 0, 1);
            pulse_en();
            w0 = nwr; r0 = nrise;
            pulse_trig(0);
            wait_flag("R6");
            chk("R6", "burst writes", nwr - w0, 10);
            chk("R6", "hold segments", nrise - r0, 3);
            chk("R6", "window with 2-cycle gaps", last_fall - rise_t[r0 % 64], 35);
            chk("R6", "second segment start", rise_t[(r0 + 1) % 64] - rise_t[r0 % 64], 15);
            cmp_mem("R3");
            clr_flag();
        end

        // Single, word to byte, source down, destination fixed, edge trigger
        begin
            int w0;
            setup(120, 400, 3, 2, 0, 1, 0, 0, 0, 1);
            ref_move(120, 400, 3, 2, 0, 1, 0);
            pulse_en();
            w0 = nwr;
            @(negedge clk) trig[1] = 1'b1;
            repeat (20) @(negedge clk);
            chk("R7", "held edge trigger moves one", nwr - w0, 1);
            chk("R4", "flag not yet", int'(dma_flag), 0);
            trig[1] = 1'b0;
            pulse_trig(1); repeat (10) @(negedge clk);
            chk("R4", "second trigger", nwr - w0, 2);
            pulse_trig(1); repeat (10) @(negedge clk);
            chk("R4", "third trigger", nwr - w0, 3);
            chk("R9", "flag on last single", int'(dma_flag), 1);
            chk("R10", "enable cleared", int'(ch_en), 0);
            cmp_mem("R2");
            clr_flag();
        end

        // Level trigger, single mode
        begin
            int w0;
            setup(200, 450, 4, 1, 1, 1, 1, 0, 1, 3);
            ref_move(200, 450, 4, 1, 1, 1, 1);
            pulse_en();
            w0 = nwr;
            @(negedge clk) trig[3] = 1'b1;
            repeat (60) @(negedge clk);
            chk("R7", "level trigger moves all", nwr - w0, 4);
            chk("R10", "enable cleared", int'(ch_en), 0);
            trig[3] = 1'b0;
            cmp_mem("R7");
            clr_flag();
        end

        // Repeated block
        begin
            int w0;
            setup(64, 260, 3, 1, 1, 1, 1, 5, 0, 0);
            ref_move(64, 260, 3, 1, 1, 1, 1);
            pulse_en();
            w0 = nwr;
            pulse_trig(0);
            wait_flag("R10");
            chk("R10", "stays enabled", int'(ch_en), 1);
            cmp_mem("R10");
            clr_flag();
            fill(64, 70);
            ref_move(64, 260, 3, 1, 1, 1, 1);
            pulse_trig(0);
            wait_flag("R10");
            chk("R10", "reloaded block writes", nwr - w0, 6);
            cmp_mem("R10");
            clr_flag();
            @(negedge clk) en_clr = 1'b1;
            @(negedge clk) en_clr = 1'b0;
            chk("R10", "disarmed", int'(ch_en), 0);
        end

        // Zero size and disabled channel
        begin
            int w0, r0;
            setup(10, 280, 0, 1, 1, 1, 1, 1, 0, 0);
            pulse_en();
            w0 = nwr; r0 = nrise;
            pulse_trig(0); repeat (20) @(negedge clk);
            chk("R11", "zero size writes", nwr - w0, 0);
            chk("R11", "zero size hold", nrise - r0, 0);
            @(negedge clk) en_clr = 1'b1;
            @(negedge clk) en_clr = 1'b0;
            setup(10, 280, 5, 1, 1, 1, 1, 1, 0, 0);
            pulse_trig(0); repeat (20) @(negedge clk);
            chk("R11", "disabled writes", nwr - w0, 0);
            chk("R11", "disabled hold", nrise - r0, 0);
            chk("R9", "no flag", int'(dma_flag), 0);
        end

        // Random configurations
        for (int it = 0; it < 10; it++) begin
            int s, d, n, ss, ds, md, w0;
            bit sw, dw;
            s = 60 + int'($urandom % 80);
            d = 300 + int'($urandom % 80);
            n = 1 + int'($urandom % 12);
            ss = int'($urandom % 4); ds = int'($urandom % 4);
            sw = 1'($urandom); dw = 1'($urandom);
            md = int'($urandom % 3);
            setup(s, d, n, ss, ds, sw, dw, md, (md == 0), 2);
            ref_move(s, d, n, ss, ds, sw, dw);
            pulse_en();
            w0 = nwr;
            @(negedge clk) trig[2] = 1'b1;
            @(negedge clk) if (md != 0) trig[2] = 1'b0;
            wait_flag("R1");
            trig[2] = 1'b0;
            chk("R1", "random writes", nwr - w0, n);
            cmp_mem("R1");
            clr_flag();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule